// File: doc/BRIEF.md
# Set-Associative Tag Directory with Line Permissions and Lock Owners

This block keeps the tag and state side of a set-associative cache. For every set it holds a number of ways. Each way stores a valid bit, the full line address, a two-bit access permission and a lock-owner context id. Each set also keeps a tree pseudo-LRU state. The data array, the coherence protocol that chooses permissions, bank arbitration and statistics all sit outside the block.

A client sends one operation per accepted request on a valid/ready channel. The operations are:
- lookup, access check by request kind and room test;
- allocate, free and victim probe;
- mark-most-recent;
- set permission;
- lock set, lock clear and lock test.

The result arrives on a valid/ready response channel in the cycle after acceptance. A response waiting for `rsp_ready` holds all its fields steady. While it waits, `req_ready` stays low, so no new request can overwrite it.

The set is chosen by `log2(SETS)` bits of the line address, starting at bit `IDX_LO`. A line is *present* when it is valid, its stored address equals the request address, and its permission is not NotPresent. Permission codes are:

| Code | Meaning |
|------|---------|
| 0 | NotPresent |
| 1 | Invalid |
| 2 | ReadOnly |
| 3 | ReadWrite |

Request kinds are:

| Code | Meaning |
|------|---------|
| 0 | load |
| 1 | instruction fetch |
| 2 and 3 | store |

Opcodes are:

| Code | Operation |
|------|-----------|
| 0 | lookup |
| 1 | access |
| 2 | room test |
| 3 | allocate |
| 4 | free |
| 5 | probe |
| 6 | touch |
| 7 | set permission |
| 8 | lock set |
| 9 | lock clear |
| 10 | lock test |

Codes 11 to 15 answer with an error and change nothing.

Top module: `assoc_tag_dir`

## Requirements
- R1: The set is `req_addr[IDX_LO +: log2(SETS)]`. Two addresses that differ in that field never compete for ways, even when every other bit is equal.
- R2: A lookup (op 0) hits only for a present line. It returns the lowest matching way and that way's permission. A stored address whose permission is NotPresent (0) answers as a miss with way 0 and permission 0. Lookup, access, room test, free, touch and set permission never report an error.
- R3: An access (op 1) is granted for a present line with permission ReadWrite (3) for any kind. With permission ReadOnly (2) it is granted only for kind 0 or 1. It is denied for stores (kind 2 or 3) to ReadOnly lines, for Invalid lines and for absent lines. A present line returns its way and permission.
- R4: An access to a present line marks that way most recent in the set's pseudo-LRU, even when the access is denied.
- R5: The room test (op 2) answers hit when the set holds a valid way with the same address, whatever its permission, or when any way is invalid or NotPresent.
- R6: Allocate (op 3) fills the lowest way that is invalid or NotPresent. The new line has permission Invalid (1) and owner all-ones, and its way is marked most recent. The response is hit with that way. If the address is already present, or the set has no such way, the response is an error and no state changes.
- R7: Free (op 4) on a present line clears its valid bit and answers hit with the way. A later lookup misses and the way can be allocated again. An absent address answers as a miss.
- R8: Probe (op 5) on a set with no room returns hit, the victim way, its stored address on `rsp_addr` and its permission. The victim is found by walking the set's pseudo-LRU tree from the root: a node bit of 1 sends the walk to the upper half of the ways. Touching a way sets each node on its path to point away from it. On a set with room, probe answers an error.
- R9: Lock set (op 8) writes `req_ctx` as the owner of a present line. Lock clear (op 9) writes all-ones. Lock test (op 10) answers hit only when the stored owner equals `req_ctx`. On an absent address each of the three answers an error and changes nothing.
- R10: Touch (op 6) marks a present line most recent and answers hit with its way. For an absent address it answers a miss and leaves the replacement state unchanged.
- R11: Set permission (op 7) writes `req_perm` into the lowest valid way whose address matches, whatever its current permission, and answers hit with that way. Otherwise it answers a miss.
- R12: A request is accepted when `req_valid` and `req_ready` are both high. Its response is valid in the next cycle. While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and every response field holds its value. After reset, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 4 | Operation code |
| req_addr | input | ADDR_W | Line address |
| req_kind | input | 2 | Access kind for op 1 |
| req_perm | input | 2 | New permission for op 7 |
| req_ctx | input | CTX_W | Context id for lock operations |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response taken this cycle |
| rsp_hit | output | 1 | Hit, grant, room or success |
| rsp_err | output | 1 | Operation not applicable |
| rsp_way | output | log2(WAYS) | Way concerned |
| rsp_perm | output | 2 | Permission of that way (lookup, access, probe) |
| rsp_addr | output | ADDR_W | Victim line address (probe) |

## Verification
The bound checker watches the channel rules on every cycle:
- a response follows each accepted request one cycle later;
- no response appears without a request;
- a stalled response does not change;
- query operations never raise the error flag;
- allocate and probe always answer exactly one of hit or error.

Replacement order, permission-based grants, lowest-free-way choice, lock ownership, and the absence of side effects from touching absent lines or failed allocations depend on stored per-set state. Only the bench scenarios can show them. The bench compares every response against a reference model of the directory.

// File: rtl/tdir_pkg.sv
package tdir_pkg;

  typedef enum logic [3:0] {
    OP_LOOKUP  = 4'd0,
    OP_ACCESS  = 4'd1,
    OP_ROOM    = 4'd2,
    OP_ALLOC   = 4'd3,
    OP_FREE    = 4'd4,
    OP_PROBE   = 4'd5,
    OP_TOUCH   = 4'd6,
    OP_SETPERM = 4'd7,
    OP_LKSET   = 4'd8,
    OP_LKCLR   = 4'd9,
    OP_LKTEST  = 4'd10
  } tdir_op_e;

  typedef enum logic [1:0] {
    PERM_NP  = 2'd0,
    PERM_INV = 2'd1,
    PERM_RO  = 2'd2,
    PERM_RW  = 2'd3
  } tdir_perm_e;

  localparam logic [1:0] KIND_LOAD  = 2'd0;
  localparam logic [1:0] KIND_FETCH = 2'd1;

endpackage

// File: rtl/tdir_match.sv
module tdir_match
  import tdir_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int ADDR_W = 12
) (
  input  logic [WAYS-1:0]   vld_i,
  input  logic [ADDR_W-1:0] addr_i [WAYS],
  input  logic [1:0]        perm_i [WAYS],
  input  logic [ADDR_W-1:0] key_i,
  output logic [WAYS-1:0]   same_o,
  output logic [WAYS-1:0]   live_o,
  output logic [WAYS-1:0]   open_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign same_o[w] = vld_i[w] && (addr_i[w] == key_i);
    assign live_o[w] = same_o[w] && (perm_i[w] != PERM_NP);
    assign open_o[w] = !vld_i[w] || (perm_i[w] == PERM_NP);
  end
endmodule

// File: rtl/tdir_pick.sv
module tdir_pick #(
  parameter int WAYS = 4,
  localparam int WB  = $clog2(WAYS)
) (
  input  logic [WAYS-1:0] vec_i,
  output logic            any_o,
  output logic [WB-1:0]   idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = WB'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/tdir_plru.sv
module tdir_plru #(
  parameter int WAYS = 4,
  localparam int LW  = $clog2(WAYS)
) (
  input  logic [WAYS-2:0] tree_i,
  input  logic [LW-1:0]   way_i,
  output logic [WAYS-2:0] tree_o,
  output logic [LW-1:0]   victim_o
);
  logic [LW:0] node_t, node_v;
  logic        bit_t, bit_v;

  // Touch: every node on the path to way_i points to the other half.
  always_comb begin
    tree_o = tree_i;
    node_t = (LW+1)'(1);
    bit_t  = 1'b0;
    for (int lvl = 0; lvl < LW; lvl++) begin
      bit_t = way_i[LW-1-lvl];
      tree_o[int'(node_t) - 1] = ~bit_t;
      node_t = {node_t[LW-1:0], bit_t};
    end
  end

  // Victim: follow node bits from the root, 1 selects the upper half.
  always_comb begin
    victim_o = '0;
    node_v   = (LW+1)'(1);
    bit_v    = 1'b0;
    for (int lvl = 0; lvl < LW; lvl++) begin
      bit_v = tree_i[int'(node_v) - 1];
      victim_o[LW-1-lvl] = bit_v;
      node_v = {node_v[LW-1:0], bit_v};
    end
  end
endmodule

// File: rtl/assoc_tag_dir.sv
module assoc_tag_dir
  import tdir_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  parameter int IDX_LO = 2,
  parameter int CTX_W  = 4,
  localparam int WB    = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_perm,
  input  logic [CTX_W-1:0]  req_ctx,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic              rsp_err,
  output logic [WB-1:0]     rsp_way,
  output logic [1:0]        rsp_perm,
  output logic [ADDR_W-1:0] rsp_addr
);
  localparam int SB    = $clog2(SETS);
  localparam int NODES = WAYS - 1;

  logic [WAYS-1:0]   vld_q [SETS];
  logic [NODES-1:0]  lru_q [SETS];
  logic [ADDR_W-1:0] adr_q [SETS][WAYS];
  logic [1:0]        prm_q [SETS][WAYS];
  logic [CTX_W-1:0]  own_q [SETS][WAYS];

  logic [SB-1:0]     set_idx;
  logic [ADDR_W-1:0] cur_adr [WAYS];
  logic [1:0]        cur_prm [WAYS];
  logic [WAYS-1:0]   same_v, live_v, open_v;
  logic              same_any, live_any, open_any;
  logic [WB-1:0]     same_way, live_way, open_way, touch_way, victim;
  logic [NODES-1:0]  lru_next;
  logic              fire, grant;
  tdir_op_e          op;

  // next response and update controls
  logic              n_hit, n_err;
  logic [WB-1:0]     n_way;
  logic [1:0]        n_perm;
  logic [ADDR_W-1:0] n_addr;
  logic              do_touch, do_alloc, do_free, do_perm, do_own;
  logic [CTX_W-1:0]  own_val;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign op        = tdir_op_e'(req_op);
  assign set_idx   = req_addr[IDX_LO +: SB];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      cur_adr[w] = adr_q[set_idx][w];
      cur_prm[w] = prm_q[set_idx][w];
    end
  end

  tdir_match #(.WAYS(WAYS), .ADDR_W(ADDR_W)) u_match (
    .vld_i (vld_q[set_idx]),
    .addr_i(cur_adr),
    .perm_i(cur_prm),
    .key_i (req_addr),
    .same_o(same_v),
    .live_o(live_v),
    .open_o(open_v)
  );

  tdir_pick #(.WAYS(WAYS)) u_pick_same (.vec_i(same_v), .any_o(same_any), .idx_o(same_way));
  tdir_pick #(.WAYS(WAYS)) u_pick_live (.vec_i(live_v), .any_o(live_any), .idx_o(live_way));
  tdir_pick #(.WAYS(WAYS)) u_pick_open (.vec_i(open_v), .any_o(open_any), .idx_o(open_way));

  assign touch_way = (op == OP_ALLOC) ? open_way : live_way;

  tdir_plru #(.WAYS(WAYS)) u_plru (
    .tree_i  (lru_q[set_idx]),
    .way_i   (touch_way),
    .tree_o  (lru_next),
    .victim_o(victim)
  );

  assign grant = live_any && ((cur_prm[live_way] == PERM_RW) ||
                 ((cur_prm[live_way] == PERM_RO) &&
                  (req_kind == KIND_LOAD || req_kind == KIND_FETCH)));

  always_comb begin
    n_hit = 1'b0; n_err = 1'b0; n_way = '0; n_perm = '0; n_addr = '0;
    do_touch = 1'b0; do_alloc = 1'b0; do_free = 1'b0;
    do_perm = 1'b0; do_own = 1'b0; own_val = '1;
    case (op)
      OP_LOOKUP: begin
        n_hit = live_any;
        if (live_any) begin n_way = live_way; n_perm = cur_prm[live_way]; end
      end
      OP_ACCESS: begin
        n_hit = grant;
        do_touch = live_any;
        if (live_any) begin n_way = live_way; n_perm = cur_prm[live_way]; end
      end
      OP_ROOM: n_hit = same_any || open_any;
      OP_ALLOC: begin
        if (live_any || !open_any) n_err = 1'b1;
        else begin
          n_hit = 1'b1; n_way = open_way; do_alloc = 1'b1; do_touch = 1'b1;
        end
      end
      OP_FREE: begin
        n_hit = live_any; do_free = live_any;
        if (live_any) n_way = live_way;
      end
      OP_PROBE: begin
        if (same_any || open_any) n_err = 1'b1;
        else begin
          n_hit = 1'b1; n_way = victim;
          n_perm = cur_prm[victim]; n_addr = cur_adr[victim];
        end
      end
      OP_TOUCH: begin
        n_hit = live_any; do_touch = live_any;
        if (live_any) n_way = live_way;
      end
      OP_SETPERM: begin
        n_hit = same_any; do_perm = same_any;
        if (same_any) n_way = same_way;
      end
      OP_LKSET, OP_LKCLR: begin
        n_hit = live_any; n_err = !live_any; do_own = live_any;
        own_val = (op == OP_LKSET) ? req_ctx : '1;
        if (live_any) n_way = live_way;
      end
      OP_LKTEST: begin
        n_hit = live_any && (own_q[set_idx][live_way] == req_ctx);
        n_err = !live_any;
        if (live_any) n_way = live_way;
      end
      default: n_err = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_way   <= '0;
      rsp_perm  <= '0;
      rsp_addr  <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        lru_q[s] <= '0;
      end
    end else begin
      if (fire) begin
        rsp_valid <= 1'b1;
        rsp_hit   <= n_hit;
        rsp_err   <= n_err;
        rsp_way   <= n_way;
        rsp_perm  <= n_perm;
        rsp_addr  <= n_addr;
        if (do_alloc) vld_q[set_idx][open_way] <= 1'b1;
        if (do_free)  vld_q[set_idx][live_way] <= 1'b0;
        if (do_touch) lru_q[set_idx] <= lru_next;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // Entry payload needs no reset: it is only read behind a valid bit.
  always_ff @(posedge clk) begin
    if (fire) begin
      if (do_alloc) begin
        adr_q[set_idx][open_way] <= req_addr;
        prm_q[set_idx][open_way] <= PERM_INV;
        own_q[set_idx][open_way] <= '1;
      end
      if (do_perm) prm_q[set_idx][same_way] <= req_perm;
      if (do_own)  own_q[set_idx][live_way] <= own_val;
    end
  end
endmodule

// File: rtl/tdir_chk.sv
module tdir_chk #(
  parameter int WB     = 2,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [3:0]        req_op,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_hit,
  input logic              rsp_err,
  input logic [WB-1:0]     rsp_way,
  input logic [1:0]        rsp_perm,
  input logic [ADDR_W-1:0] rsp_addr
);
  logic acc, query_op, answer_op;
  assign acc       = req_valid && req_ready;
  assign query_op  = (req_op == 4'd0) || (req_op == 4'd1) || (req_op == 4'd2) ||
                     (req_op == 4'd4) || (req_op == 4'd6) || (req_op == 4'd7);
  assign answer_op = (req_op == 4'd3) || (req_op == 4'd5);

  p_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  p_no_orphan_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(acc));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_err) &&
      $stable(rsp_way) && $stable(rsp_perm) && $stable(rsp_addr)));

  p_query_no_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && query_op) |=> !rsp_err);

  p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && answer_op) |=> (rsp_hit != rsp_err));
endmodule

bind assoc_tag_dir tdir_chk #(.WB(WB), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_assoc_tag_dir.sv
module tb_assoc_tag_dir;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12, NS = 4, NW = 4, LO = 2, CW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, rsp_ready = 1'b0;
  logic [3:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_kind = '0, req_perm = '0;
  logic [CW-1:0] req_ctx = '0;
  logic req_ready, rsp_valid, rsp_hit, rsp_err;
  logic [1:0] rsp_way, rsp_perm;
  logic [AW-1:0] rsp_addr;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assoc_tag_dir #(.ADDR_W(AW), .SETS(NS), .WAYS(NW), .IDX_LO(LO), .CTX_W(CW)) dut (.*);

  // reference model
  bit          mv [NS][NW];
  logic [AW-1:0] ma [NS][NW];
  logic [1:0]  mp [NS][NW];
  logic [CW-1:0] mo [NS][NW];
  bit          mt [NS][NW];   // node 1..NW-1, 1 = victim in upper half

  function automatic void m_touch(int s, int w);
    int node = 1, lo = 0, size = NW;
    while (size > 1) begin
      int half = size / 2;
      if (w < lo + half) begin mt[s][node] = 1; node = 2*node; end
      else begin mt[s][node] = 0; node = 2*node + 1; lo += half; end
      size = half;
    end
  endfunction

  function automatic int m_victim(int s);
    int node = 1, lo = 0, size = NW;
    while (size > 1) begin
      int half = size / 2;
      if (mt[s][node]) begin lo += half; node = 2*node + 1; end
      else node = 2*node;
      size = half;
    end
    return lo;
  endfunction

  function automatic void model(input logic [3:0] op, input logic [AW-1:0] a,
      input logic [1:0] kind, input logic [1:0] perm, input logic [CW-1:0] ctx,
      output logic e_hit, output logic e_err, output logic [1:0] e_way,
      output logic [1:0] e_perm, output logic [AW-1:0] e_addr);
    int s = int'(a[LO +: 2]);
    int pw = -1, sw = -1, ow = -1;
    for (int w = NW - 1; w >= 0; w--) begin
      if (mv[s][w] && ma[s][w] == a) begin
        sw = w;
        if (mp[s][w] != 2'd0) pw = w;
      end
      if (!mv[s][w] || mp[s][w] == 2'd0) ow = w;
    end
    e_hit = 0; e_err = 0; e_way = 0; e_perm = 0; e_addr = 0;
    case (op)
      4'd0: if (pw >= 0) begin e_hit = 1; e_way = 2'(pw); e_perm = mp[s][pw]; end
      4'd1: if (pw >= 0) begin
              e_way = 2'(pw); e_perm = mp[s][pw];
              e_hit = (mp[s][pw] == 2'd3) || (mp[s][pw] == 2'd2 && kind <= 2'd1);
              m_touch(s, pw);
            end
      4'd2: e_hit = (sw >= 0) || (ow >= 0);
      4'd3: if (pw >= 0 || ow < 0) e_err = 1;
            else begin
              e_hit = 1; e_way = 2'(ow);
              mv[s][ow] = 1; ma[s][ow] = a; mp[s][ow] = 2'd1; mo[s][ow] = '1;
              m_touch(s, ow);
            end
      4'd4: if (pw >= 0) begin e_hit = 1; e_way = 2'(pw); mv[s][pw] = 0; end
      4'd5: if (sw >= 0 || ow >= 0) e_err = 1;
            else begin
              int v = m_victim(s);
              e_hit = 1; e_way = 2'(v); e_perm = mp[s][v]; e_addr = ma[s][v];
            end
      4'd6: if (pw >= 0) begin e_hit = 1; e_way = 2'(pw); m_touch(s, pw); end
      4'd7: if (sw >= 0) begin e_hit = 1; e_way = 2'(sw); mp[s][sw] = perm; end
      4'd8, 4'd9: if (pw >= 0) begin
              e_hit = 1; e_way = 2'(pw);
              mo[s][pw] = (op == 4'd8) ? ctx : '1;
            end else e_err = 1;
      4'd10: if (pw >= 0) begin e_way = 2'(pw); e_hit = (mo[s][pw] == ctx); end
             else e_err = 1;
      default: e_err = 1;
    endcase
  endfunction

  function automatic string req_of(logic [3:0] op);
    case (op)
      4'd0: return "R2";  4'd1: return "R3";  4'd2: return "R5";
      4'd3: return "R6";  4'd4: return "R7";  4'd5: return "R8";
      4'd6: return "R10"; 4'd7: return "R11";
      4'd8, 4'd9, 4'd10: return "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one operation; label "" means use the opcode's requirement
  task automatic do_op(logic [3:0] op, logic [AW-1:0] a, logic [1:0] kind,
                       logic [1:0] perm, logic [CW-1:0] ctx, string label, int stall);
    logic e_hit, e_err; logic [1:0] e_way, e_perm; logic [AW-1:0] e_addr;
    string rq;
    rq = (label == "") ? req_of(op) : label;
    model(op, a, kind, perm, ctx, e_hit, e_err, e_way, e_perm, e_addr);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_kind = kind;
    req_perm = perm; req_ctx = ctx; rsp_ready = 0;
    @(negedge clk);
    req_valid = 0;
    check("R12", "rsp_valid after accept", 32'(rsp_valid), 32'd1);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      check("R12", "stalled hold", {rsp_valid, req_ready, rsp_hit, rsp_err},
            {1'b1, 1'b0, e_hit, e_err});
    end
    check(rq, $sformatf("op%0d response", op),
          {rsp_hit, rsp_err, rsp_way, rsp_perm, rsp_addr},
          {e_hit, e_err, e_way, e_perm, e_addr});
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  localparam logic [AW-1:0] A = 12'h004, B = 12'h014, C = 12'h024,
                            D = 12'h034, E = 12'h044, F = 12'h054, G = 12'h008;

  initial begin
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin mv[s][w] = 0; mt[s][w] = 0; end
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R12", "reset rsp_valid/req_ready", {rsp_valid, req_ready}, 2'b01);

    do_op(0, A, 0, 0, 0, "R2", 0);          // miss on empty
    do_op(3, A, 0, 0, 0, "R6", 1);          // way 0
    do_op(0, A, 0, 0, 0, "R6", 0);          // perm Invalid
    do_op(10, A, 0, 0, 4'hF, "R6", 0);      // owner all-ones
    do_op(1, A, 0, 0, 0, "R3", 0);          // Invalid -> denied
    do_op(7, A, 0, 2'd0, 0, "R11", 0);      // to NotPresent
    do_op(0, A, 0, 0, 0, "R2", 0);          // NotPresent misses
    do_op(2, A, 0, 0, 0, "R5", 0);
    do_op(3, A, 0, 0, 0, "R6", 0);          // reuses NotPresent way 0
    do_op(7, A, 0, 2'd2, 0, "R11", 0);      // ReadOnly
    do_op(1, A, 2'd0, 0, 0, "R3", 0);       // load granted
    do_op(1, A, 2'd1, 0, 0, "R3", 0);       // fetch granted
    do_op(1, A, 2'd2, 0, 0, "R3", 2);       // store denied
    do_op(3, B, 0, 0, 0, "R1", 0);
    do_op(3, C, 0, 0, 0, "R6", 0);
    do_op(3, D, 0, 0, 0, "R6", 0);
    do_op(3, E, 0, 0, 0, "R6", 0);          // full -> error
    do_op(3, A, 0, 0, 0, "R6", 0);          // present -> error
    do_op(2, E, 0, 0, 0, "R5", 0);          // no room
    do_op(2, B, 0, 0, 0, "R5", 0);          // already present
    do_op(5, E, 0, 0, 0, "R8", 0);
    do_op(1, A, 2'd2, 0, 0, "R4", 0);       // denied but touches
    do_op(5, E, 0, 0, 0, "R4", 0);
    do_op(6, E, 0, 0, 0, "R10", 0);         // absent -> ignored
    do_op(5, E, 0, 0, 0, "R10", 0);
    do_op(3, G, 0, 0, 0, "R1", 0);          // other set still open
    do_op(5, G, 0, 0, 0, "R8", 0);          // room -> error
    do_op(8, A, 0, 0, 4'd3, "R9", 0);
    do_op(10, A, 0, 0, 4'd3, "R9", 0);
    do_op(10, A, 0, 0, 4'd4, "R9", 0);
    do_op(9, A, 0, 0, 0, "R9", 0);
    do_op(10, A, 0, 0, 4'd3, "R9", 0);
    do_op(8, E, 0, 0, 4'd3, "R9", 0);       // absent -> error
    do_op(4, B, 0, 0, 0, "R7", 0);
    do_op(0, B, 0, 0, 0, "R7", 0);
    do_op(3, F, 0, 0, 0, "R7", 0);          // refills way 1
    do_op(4'd12, A, 0, 0, 0, "R12", 0);     // undefined opcode

    for (int n = 0; n < 1500; n++) begin
      int r = int'($urandom % 16);
      logic [3:0] op;
      logic [AW-1:0] a = {6'b0, 6'($urandom)};
      case (r)
        0, 1, 2: op = 0;  3, 4: op = 1;  5: op = 2;
        6, 7, 8: op = 3;  9: op = 4;     10: op = 5;
        11: op = 6;       12, 13: op = 7;
        14: op = 4'(8 + ($urandom % 3));
        default: op = 4'(11 + ($urandom % 5));
      endcase
      do_op(op, a, 2'($urandom), 2'($urandom), 4'($urandom % 5), "", int'($urandom % 3));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R12 watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule